// File: doc/BRIEF.md
# Memory Dependency Group Tracker

This block keeps the dependency bookkeeping for a fixed table of memory-operation groups inside an out-of-order core model. A group is a set of memory operations that share the same dependencies and do not depend on each other. For each group the block counts its member operations, how many of them have issued and how many have finished. It also counts its predecessor groups and how many of those are executing or finished. From these counts it derives a readiness level and an execution state for every group.

Groups are linked by successor edges of two kinds. An ordering edge is released as soon as every remaining member of the source group has issued. A data edge first reports the source as executing and is released only when every member of the source has finished. Data edges also carry a remaining-cycle estimate. The receiving group keeps the largest such estimate, together with the instruction ID it came from, as its critical predecessor. A per-cycle tick counts that estimate down while the group still waits on predecessors whose finish time is not known.

Events arrive on dedicated ports, each tagged with a group index. All state is registered. The outputs are per-group flag vectors, the critical-predecessor record of one selected group, and a sticky error flag.

Top module: `mem_dep_tracker`

## Requirements
- R1: During and straight after a synchronous reset, every valid group (indices 1 to NUM_GROUPS-1) reads ready and executed, and not waiting, pending or executing. Group 0 reads all flags clear. The critical-predecessor outputs and the error flag read 0.
- R2: Each add-member event raises the member count of its group by one, so the group becomes executing only once that many members have issued. Adding a member to a group that already has a successor edge is illegal.
- R3: A group is waiting when its predecessor count exceeds executing plus finished predecessors. It is pending when at least one predecessor is executing and executing plus finished equals the total. It is ready when finished equals the total. At most one of these three holds.
- R4: A group is executing when its issued-but-unfinished count is nonzero and equals members minus finished members. It is executed when finished equals members. The two never hold together.
- R5: When an issue makes the source group executing, each ordering successor counts that predecessor as finished at once.
- R6: When an issue makes the source group executing, each data successor counts it as executing. When the last member of the source finishes, each data successor moves that predecessor from executing to finished.
- R7: An ordering edge added from a source that is already executing is dropped and adds no predecessor. A data edge from such a source adds a predecessor that is already counted as executing, and it passes on the source's critical instruction.
- R8: A data-edge issue event replaces the receiver's critical predecessor only when its cycle count is strictly larger than the one held. The record holds a cycle count and an instruction ID.
- R9: On a tick, every waiting group with a nonzero critical-predecessor cycle count decrements that count by one. Groups that are not waiting keep their count.
- R10: Each group keeps, as its critical instruction, the issued member with the largest cycle count. It passes this on to data successors only when the group becomes executing, and it clears the record when that same instruction finishes.
- R11: Events arriving in the same cycle take effect in a fixed order: add-member, add-edge, issue, execute, tick. An issue and an execute of the same group in one cycle are therefore legal.
- R12: An illegal event sets the sticky error flag and leaves all state unchanged. Illegal events are: group index 0, adding a member to a group with successors, issuing with no unissued member, executing with no issued member or in a non-ready group, and an edge from an executed source, to itself, or one that already exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| add_inst_vld | input | 1 | Add one member to a group |
| add_inst_grp | input | IDX_W | Group receiving the member |
| add_succ_vld | input | 1 | Add a successor edge |
| add_succ_src | input | IDX_W | Older (source) group of the edge |
| add_succ_dst | input | IDX_W | Younger (successor) group of the edge |
| add_succ_data | input | 1 | 1 = data edge, 0 = ordering edge |
| iss_vld | input | 1 | A member instruction issued |
| iss_grp | input | IDX_W | Group of the issued instruction |
| iss_iid | input | IID_W | Instruction ID of the issued instruction |
| iss_cyc | input | CYC_W | Remaining cycles of the issued instruction |
| exe_vld | input | 1 | A member instruction finished |
| exe_grp | input | IDX_W | Group of the finished instruction |
| exe_iid | input | IID_W | Instruction ID of the finished instruction |
| tick | input | 1 | One model cycle elapsed |
| crit_sel | input | IDX_W | Group whose critical predecessor is reported |
| grp_waiting | output | NUM_GROUPS | Per-group waiting flag |
| grp_pending | output | NUM_GROUPS | Per-group pending flag |
| grp_ready | output | NUM_GROUPS | Per-group ready flag |
| grp_executing | output | NUM_GROUPS | Per-group executing flag |
| grp_executed | output | NUM_GROUPS | Per-group executed flag |
| crit_pred_cyc | output | CYC_W | Critical-predecessor cycle count of the selected group |
| crit_pred_iid | output | IID_W | Critical-predecessor instruction ID of the selected group |
| err_flag | output | 1 | Sticky illegal-event flag |

## Verification
The bench builds the block with its defaults: 16 groups, 4-bit counters, 8-bit cycle counts and 8-bit instruction IDs. Fifteen usable groups let every scenario start from fresh groups in their reset state. This covers two-member groups, fan-in of two data edges into one group, and edges added after the source has started. The 8-bit counts are wide enough for a countdown that is watched over several ticks, and the sticky error case runs last so the earlier scenarios are checked with the flag clear.

// File: rtl/dep_grp_pkg.sv
package dep_grp_pkg;

  typedef enum logic [1:0] {
    LVL_NONE  = 2'd0,
    LVL_WAIT  = 2'd1,
    LVL_PEND  = 2'd2,
    LVL_READY = 2'd3
  } dep_level_e;

endpackage

// File: rtl/dep_status_flags.sv
module dep_status_flags #(
  parameter int NUM_GROUPS = 16,
  parameter int CNT_W      = 4
) (
  input  logic [NUM_GROUPS-1:0][CNT_W-1:0] npred,
  input  logic [NUM_GROUPS-1:0][CNT_W-1:0] pexe,
  input  logic [NUM_GROUPS-1:0][CNT_W-1:0] pdone,
  input  logic [NUM_GROUPS-1:0][CNT_W-1:0] ninst,
  input  logic [NUM_GROUPS-1:0][CNT_W-1:0] nexe,
  input  logic [NUM_GROUPS-1:0][CNT_W-1:0] ndone,
  output logic [NUM_GROUPS-1:0]            waiting,
  output logic [NUM_GROUPS-1:0]            pending,
  output logic [NUM_GROUPS-1:0]            ready,
  output logic [NUM_GROUPS-1:0]            executing,
  output logic [NUM_GROUPS-1:0]            executed
);
  import dep_grp_pkg::*;

  assign waiting[0]   = 1'b0;
  assign pending[0]   = 1'b0;
  assign ready[0]     = 1'b0;
  assign executing[0] = 1'b0;
  assign executed[0]  = 1'b0;

  for (genvar g = 1; g < NUM_GROUPS; g++) begin : g_grp
    dep_level_e  lvl;
    logic [CNT_W:0] pred_seen;
    logic [CNT_W-1:0] open_cnt;

    assign pred_seen = {1'b0, pexe[g]} + {1'b0, pdone[g]};
    assign open_cnt  = ninst[g] - ndone[g];

    always_comb begin
      if (pdone[g] == npred[g])
        lvl = LVL_READY;
      else if ({1'b0, npred[g]} > pred_seen)
        lvl = LVL_WAIT;
      else if ((pexe[g] != '0) && (pred_seen == {1'b0, npred[g]}))
        lvl = LVL_PEND;
      else
        lvl = LVL_NONE;
    end

    assign waiting[g]   = (lvl == LVL_WAIT);
    assign pending[g]   = (lvl == LVL_PEND);
    assign ready[g]     = (lvl == LVL_READY);
    assign executing[g] = (nexe[g] != '0) && (nexe[g] == open_cnt);
    assign executed[g]  = (ndone[g] == ninst[g]);
  end

endmodule

// File: rtl/dep_next_state.sv
module dep_next_state #(
  parameter int NUM_GROUPS = 16,
  parameter int CNT_W      = 4,
  parameter int CYC_W      = 8,
  parameter int IID_W      = 8,
  localparam int IDX_W     = $clog2(NUM_GROUPS)
) (
  input  logic [NUM_GROUPS-1:0][CNT_W-1:0]      c_npred,
  input  logic [NUM_GROUPS-1:0][CNT_W-1:0]      c_pexe,
  input  logic [NUM_GROUPS-1:0][CNT_W-1:0]      c_pdone,
  input  logic [NUM_GROUPS-1:0][CNT_W-1:0]      c_ninst,
  input  logic [NUM_GROUPS-1:0][CNT_W-1:0]      c_nexe,
  input  logic [NUM_GROUPS-1:0][CNT_W-1:0]      c_ndone,
  input  logic [NUM_GROUPS-1:0][NUM_GROUPS-1:0] c_ord,
  input  logic [NUM_GROUPS-1:0][NUM_GROUPS-1:0] c_dat,
  input  logic [NUM_GROUPS-1:0]                 c_ci_vld,
  input  logic [NUM_GROUPS-1:0][IID_W-1:0]      c_ci_iid,
  input  logic [NUM_GROUPS-1:0][CYC_W-1:0]      c_ci_cyc,
  input  logic [NUM_GROUPS-1:0][IID_W-1:0]      c_cp_iid,
  input  logic [NUM_GROUPS-1:0][CYC_W-1:0]      c_cp_cyc,
  input  logic                                  add_inst_vld,
  input  logic [IDX_W-1:0]                      add_inst_grp,
  input  logic                                  add_succ_vld,
  input  logic [IDX_W-1:0]                      add_succ_src,
  input  logic [IDX_W-1:0]                      add_succ_dst,
  input  logic                                  add_succ_data,
  input  logic                                  iss_vld,
  input  logic [IDX_W-1:0]                      iss_grp,
  input  logic [IID_W-1:0]                      iss_iid,
  input  logic [CYC_W-1:0]                      iss_cyc,
  input  logic                                  exe_vld,
  input  logic [IDX_W-1:0]                      exe_grp,
  input  logic [IID_W-1:0]                      exe_iid,
  input  logic                                  tick,
  output logic [NUM_GROUPS-1:0][CNT_W-1:0]      n_npred,
  output logic [NUM_GROUPS-1:0][CNT_W-1:0]      n_pexe,
  output logic [NUM_GROUPS-1:0][CNT_W-1:0]      n_pdone,
  output logic [NUM_GROUPS-1:0][CNT_W-1:0]      n_ninst,
  output logic [NUM_GROUPS-1:0][CNT_W-1:0]      n_nexe,
  output logic [NUM_GROUPS-1:0][CNT_W-1:0]      n_ndone,
  output logic [NUM_GROUPS-1:0][NUM_GROUPS-1:0] n_ord,
  output logic [NUM_GROUPS-1:0][NUM_GROUPS-1:0] n_dat,
  output logic [NUM_GROUPS-1:0]                 n_ci_vld,
  output logic [NUM_GROUPS-1:0][IID_W-1:0]      n_ci_iid,
  output logic [NUM_GROUPS-1:0][CYC_W-1:0]      n_ci_cyc,
  output logic [NUM_GROUPS-1:0][IID_W-1:0]      n_cp_iid,
  output logic [NUM_GROUPS-1:0][CYC_W-1:0]      n_cp_cyc,
  output logic                                  err_evt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] up(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] down(input logic [CNT_W-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  function automatic logic is_exec(input logic [CNT_W-1:0] ex,
                                   input logic [CNT_W-1:0] tot,
                                   input logic [CNT_W-1:0] dn);
    return (ex != '0) && (ex == CNT_W'(tot - dn));
  endfunction

  function automatic logic is_wait(input logic [CNT_W-1:0] np,
                                   input logic [CNT_W-1:0] pe,
                                   input logic [CNT_W-1:0] pd);
    return {1'b0, np} > ({1'b0, pe} + {1'b0, pd});
  endfunction

  always_comb begin
    n_npred  = c_npred;
    n_pexe   = c_pexe;
    n_pdone  = c_pdone;
    n_ninst  = c_ninst;
    n_nexe   = c_nexe;
    n_ndone  = c_ndone;
    n_ord    = c_ord;
    n_dat    = c_dat;
    n_ci_vld = c_ci_vld;
    n_ci_iid = c_ci_iid;
    n_ci_cyc = c_ci_cyc;
    n_cp_iid = c_cp_iid;
    n_cp_cyc = c_cp_cyc;
    err_evt  = 1'b0;

    // stage 1: new member
    if (add_inst_vld) begin
      if ((add_inst_grp == '0) ||
          ((n_ord[add_inst_grp] | n_dat[add_inst_grp]) != '0))
        err_evt = 1'b1;
      else
        n_ninst[add_inst_grp] = up(n_ninst[add_inst_grp]);
    end

    // stage 2: new successor edge
    if (add_succ_vld) begin
      if ((add_succ_src == '0) || (add_succ_dst == '0) ||
          (add_succ_src == add_succ_dst) ||
          (n_ndone[add_succ_src] == n_ninst[add_succ_src]) ||
          n_ord[add_succ_src][add_succ_dst] || n_dat[add_succ_src][add_succ_dst]) begin
        err_evt = 1'b1;
      end else if (is_exec(n_nexe[add_succ_src], n_ninst[add_succ_src],
                           n_ndone[add_succ_src])) begin
        if (add_succ_data) begin
          n_dat[add_succ_src][add_succ_dst] = 1'b1;
          n_npred[add_succ_dst] = up(n_npred[add_succ_dst]);
          n_pexe[add_succ_dst]  = up(n_pexe[add_succ_dst]);
          if (n_ci_cyc[add_succ_src] > n_cp_cyc[add_succ_dst]) begin
            n_cp_cyc[add_succ_dst] = n_ci_cyc[add_succ_src];
            n_cp_iid[add_succ_dst] = n_ci_iid[add_succ_src];
          end
        end
      end else begin
        n_npred[add_succ_dst] = up(n_npred[add_succ_dst]);
        if (add_succ_data) n_dat[add_succ_src][add_succ_dst] = 1'b1;
        else               n_ord[add_succ_src][add_succ_dst] = 1'b1;
      end
    end

    // stage 3: member issued
    if (iss_vld) begin
      if ((iss_grp == '0) ||
          (({1'b0, n_nexe[iss_grp]} + {1'b0, n_ndone[iss_grp]}) >= {1'b0, n_ninst[iss_grp]})) begin
        err_evt = 1'b1;
      end else begin
        n_nexe[iss_grp] = up(n_nexe[iss_grp]);
        if (!n_ci_vld[iss_grp] || (n_ci_cyc[iss_grp] < iss_cyc)) begin
          n_ci_vld[iss_grp] = 1'b1;
          n_ci_iid[iss_grp] = iss_iid;
          n_ci_cyc[iss_grp] = iss_cyc;
        end
        if (is_exec(n_nexe[iss_grp], n_ninst[iss_grp], n_ndone[iss_grp])) begin
          for (int j = 1; j < NUM_GROUPS; j++) begin
            if (n_ord[iss_grp][j]) n_pdone[j] = up(n_pdone[j]);
            if (n_dat[iss_grp][j]) begin
              n_pexe[j] = up(n_pexe[j]);
              if (n_ci_cyc[iss_grp] > n_cp_cyc[j]) begin
                n_cp_cyc[j] = n_ci_cyc[iss_grp];
                n_cp_iid[j] = n_ci_iid[iss_grp];
              end
            end
          end
        end
      end
    end

    // stage 4: member finished
    if (exe_vld) begin
      if ((exe_grp == '0) || (n_nexe[exe_grp] == '0) ||
          (n_pdone[exe_grp] != n_npred[exe_grp])) begin
        err_evt = 1'b1;
      end else begin
        n_nexe[exe_grp]  = down(n_nexe[exe_grp]);
        n_ndone[exe_grp] = up(n_ndone[exe_grp]);
        if (n_ci_vld[exe_grp] && (n_ci_iid[exe_grp] == exe_iid)) begin
          n_ci_vld[exe_grp] = 1'b0;
          n_ci_cyc[exe_grp] = '0;
        end
        if (n_ndone[exe_grp] == n_ninst[exe_grp]) begin
          for (int j = 1; j < NUM_GROUPS; j++) begin
            if (n_dat[exe_grp][j]) begin
              n_pexe[j]  = down(n_pexe[j]);
              n_pdone[j] = up(n_pdone[j]);
            end
          end
        end
      end
    end

    // stage 5: cycle countdown
    if (tick) begin
      for (int j = 1; j < NUM_GROUPS; j++) begin
        if (is_wait(n_npred[j], n_pexe[j], n_pdone[j]) && (n_cp_cyc[j] != '0))
          n_cp_cyc[j] = n_cp_cyc[j] - 1'b1;
      end
    end
  end

endmodule

// File: rtl/mem_dep_tracker.sv
module mem_dep_tracker #(
  parameter int NUM_GROUPS = 16,
  parameter int CNT_W      = 4,
  parameter int CYC_W      = 8,
  parameter int IID_W      = 8,
  localparam int IDX_W     = $clog2(NUM_GROUPS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  add_inst_vld,
  input  logic [IDX_W-1:0]      add_inst_grp,
  input  logic                  add_succ_vld,
  input  logic [IDX_W-1:0]      add_succ_src,
  input  logic [IDX_W-1:0]      add_succ_dst,
  input  logic                  add_succ_data,
  input  logic                  iss_vld,
  input  logic [IDX_W-1:0]      iss_grp,
  input  logic [IID_W-1:0]      iss_iid,
  input  logic [CYC_W-1:0]      iss_cyc,
  input  logic                  exe_vld,
  input  logic [IDX_W-1:0]      exe_grp,
  input  logic [IID_W-1:0]      exe_iid,
  input  logic                  tick,
  input  logic [IDX_W-1:0]      crit_sel,
  output logic [NUM_GROUPS-1:0] grp_waiting,
  output logic [NUM_GROUPS-1:0] grp_pending,
  output logic [NUM_GROUPS-1:0] grp_ready,
  output logic [NUM_GROUPS-1:0] grp_executing,
  output logic [NUM_GROUPS-1:0] grp_executed,
  output logic [CYC_W-1:0]      crit_pred_cyc,
  output logic [IID_W-1:0]      crit_pred_iid,
  output logic                  err_flag
);

  localparam logic [NUM_GROUPS-1:0] VALID_MASK = {{(NUM_GROUPS-1){1'b1}}, 1'b0};

  logic [NUM_GROUPS-1:0][CNT_W-1:0]      npred_q, pexe_q, pdone_q, ninst_q, nexe_q, ndone_q;
  logic [NUM_GROUPS-1:0][CNT_W-1:0]      npred_d, pexe_d, pdone_d, ninst_d, nexe_d, ndone_d;
  logic [NUM_GROUPS-1:0][NUM_GROUPS-1:0] ord_q, dat_q, ord_d, dat_d;
  logic [NUM_GROUPS-1:0]                 ci_vld_q, ci_vld_d;
  logic [NUM_GROUPS-1:0][IID_W-1:0]      ci_iid_q, ci_iid_d, cp_iid_q, cp_iid_d;
  logic [NUM_GROUPS-1:0][CYC_W-1:0]      ci_cyc_q, ci_cyc_d, cp_cyc_q, cp_cyc_d;
  logic                                  err_evt;
  logic [NUM_GROUPS-1:0] f_wait, f_pend, f_rdy, f_exing, f_exed;

  dep_next_state #(
    .NUM_GROUPS(NUM_GROUPS), .CNT_W(CNT_W), .CYC_W(CYC_W), .IID_W(IID_W)
  ) u_next (
    .c_npred(npred_q), .c_pexe(pexe_q), .c_pdone(pdone_q),
    .c_ninst(ninst_q), .c_nexe(nexe_q), .c_ndone(ndone_q),
    .c_ord(ord_q), .c_dat(dat_q),
    .c_ci_vld(ci_vld_q), .c_ci_iid(ci_iid_q), .c_ci_cyc(ci_cyc_q),
    .c_cp_iid(cp_iid_q), .c_cp_cyc(cp_cyc_q),
    .add_inst_vld(add_inst_vld), .add_inst_grp(add_inst_grp),
    .add_succ_vld(add_succ_vld), .add_succ_src(add_succ_src),
    .add_succ_dst(add_succ_dst), .add_succ_data(add_succ_data),
    .iss_vld(iss_vld), .iss_grp(iss_grp), .iss_iid(iss_iid), .iss_cyc(iss_cyc),
    .exe_vld(exe_vld), .exe_grp(exe_grp), .exe_iid(exe_iid),
    .tick(tick),
    .n_npred(npred_d), .n_pexe(pexe_d), .n_pdone(pdone_d),
    .n_ninst(ninst_d), .n_nexe(nexe_d), .n_ndone(ndone_d),
    .n_ord(ord_d), .n_dat(dat_d),
    .n_ci_vld(ci_vld_d), .n_ci_iid(ci_iid_d), .n_ci_cyc(ci_cyc_d),
    .n_cp_iid(cp_iid_d), .n_cp_cyc(cp_cyc_d),
    .err_evt(err_evt)
  );

  dep_status_flags #(
    .NUM_GROUPS(NUM_GROUPS), .CNT_W(CNT_W)
  ) u_flags (
    .npred(npred_d), .pexe(pexe_d), .pdone(pdone_d),
    .ninst(ninst_d), .nexe(nexe_d), .ndone(ndone_d),
    .waiting(f_wait), .pending(f_pend), .ready(f_rdy),
    .executing(f_exing), .executed(f_exed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      npred_q  <= '0;
      pexe_q   <= '0;
      pdone_q  <= '0;
      ninst_q  <= '0;
      nexe_q   <= '0;
      ndone_q  <= '0;
      ord_q    <= '0;
      dat_q    <= '0;
      ci_vld_q <= '0;
      ci_iid_q <= '0;
      ci_cyc_q <= '0;
      cp_iid_q <= '0;
      cp_cyc_q <= '0;
    end else begin
      npred_q  <= npred_d;
      pexe_q   <= pexe_d;
      pdone_q  <= pdone_d;
      ninst_q  <= ninst_d;
      nexe_q   <= nexe_d;
      ndone_q  <= ndone_d;
      ord_q    <= ord_d;
      dat_q    <= dat_d;
      ci_vld_q <= ci_vld_d;
      ci_iid_q <= ci_iid_d;
      ci_cyc_q <= ci_cyc_d;
      cp_iid_q <= cp_iid_d;
      cp_cyc_q <= cp_cyc_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_waiting   <= '0;
      grp_pending   <= '0;
      grp_ready     <= VALID_MASK;
      grp_executing <= '0;
      grp_executed  <= VALID_MASK;
      crit_pred_cyc <= '0;
      crit_pred_iid <= '0;
      err_flag      <= 1'b0;
    end else begin
      grp_waiting   <= f_wait;
      grp_pending   <= f_pend;
      grp_ready     <= f_rdy;
      grp_executing <= f_exing;
      grp_executed  <= f_exed;
      crit_pred_cyc <= cp_cyc_d[crit_sel];
      crit_pred_iid <= cp_iid_d[crit_sel];
      err_flag      <= err_flag | err_evt;
    end
  end

endmodule

// File: rtl/mem_dep_tracker_chk.sv
module mem_dep_tracker_chk #(
  parameter int NUM_GROUPS = 16,
  parameter int CYC_W      = 8,
  parameter int IDX_W      = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  add_succ_vld,
  input logic                  iss_vld,
  input logic                  tick,
  input logic [IDX_W-1:0]      crit_sel,
  input logic [NUM_GROUPS-1:0] grp_waiting,
  input logic [NUM_GROUPS-1:0] grp_pending,
  input logic [NUM_GROUPS-1:0] grp_ready,
  input logic [NUM_GROUPS-1:0] grp_executing,
  input logic [NUM_GROUPS-1:0] grp_executed,
  input logic [CYC_W-1:0]      crit_pred_cyc,
  input logic                  err_flag
);

  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);

  // R3
  level_excl_chk: assert property (@(posedge clk) disable iff (rst)
    ((grp_waiting & grp_pending) == '0) && ((grp_waiting & grp_ready) == '0) &&
    ((grp_pending & grp_ready) == '0));

  // R4
  exec_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (grp_executing & grp_executed) == '0);

  // R9
  crit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !iss_vld && !add_succ_vld && $stable(crit_sel)) |=> $stable(crit_pred_cyc));

  // R1
  grp0_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(grp_waiting[0] || grp_pending[0] || grp_ready[0] || grp_executing[0] || grp_executed[0]));

endmodule

bind mem_dep_tracker mem_dep_tracker_chk #(
  .NUM_GROUPS(NUM_GROUPS), .CYC_W(CYC_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .add_succ_vld(add_succ_vld), .iss_vld(iss_vld),
  .tick(tick), .crit_sel(crit_sel),
  .grp_waiting(grp_waiting), .grp_pending(grp_pending), .grp_ready(grp_ready),
  .grp_executing(grp_executing), .grp_executed(grp_executed),
  .crit_pred_cyc(crit_pred_cyc), .err_flag(err_flag)
);

// File: tb/mem_dep_tracker_tb.sv
module mem_dep_tracker_tb;
  localparam int NG = 16;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic add_inst_vld = 0; logic [IW-1:0] add_inst_grp = '0;
  logic add_succ_vld = 0; logic [IW-1:0] add_succ_src = '0, add_succ_dst = '0;
  logic add_succ_data = 0;
  logic iss_vld = 0; logic [IW-1:0] iss_grp = '0; logic [7:0] iss_iid = '0, iss_cyc = '0;
  logic exe_vld = 0; logic [IW-1:0] exe_grp = '0; logic [7:0] exe_iid = '0;
  logic tick = 0; logic [IW-1:0] crit_sel = '0;
  logic [NG-1:0] grp_waiting, grp_pending, grp_ready, grp_executing, grp_executed;
  logic [7:0] crit_pred_cyc, crit_pred_iid;
  logic err_flag;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4ns clk = ~clk;

  mem_dep_tracker u_dut (
    .clk(clk), .rst(rst),
    .add_inst_vld(add_inst_vld), .add_inst_grp(add_inst_grp),
    .add_succ_vld(add_succ_vld), .add_succ_src(add_succ_src),
    .add_succ_dst(add_succ_dst), .add_succ_data(add_succ_data),
    .iss_vld(iss_vld), .iss_grp(iss_grp), .iss_iid(iss_iid), .iss_cyc(iss_cyc),
    .exe_vld(exe_vld), .exe_grp(exe_grp), .exe_iid(exe_iid),
    .tick(tick), .crit_sel(crit_sel),
    .grp_waiting(grp_waiting), .grp_pending(grp_pending), .grp_ready(grp_ready),
    .grp_executing(grp_executing), .grp_executed(grp_executed),
    .crit_pred_cyc(crit_pred_cyc), .crit_pred_iid(crit_pred_iid), .err_flag(err_flag)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clr();
    add_inst_vld = 0; add_succ_vld = 0; iss_vld = 0; exe_vld = 0; tick = 0;
  endtask

  task automatic add_inst(input int g);
    add_inst_vld = 1; add_inst_grp = IW'(g);
    @(negedge clk); clr();
  endtask

  task automatic add_succ(input int s, input int d, input bit data);
    add_succ_vld = 1; add_succ_src = IW'(s); add_succ_dst = IW'(d); add_succ_data = data;
    @(negedge clk); clr();
  endtask

  task automatic issue(input int g, input int iid, input int cyc);
    iss_vld = 1; iss_grp = IW'(g); iss_iid = 8'(iid); iss_cyc = 8'(cyc);
    @(negedge clk); clr();
  endtask

  task automatic execute(input int g, input int iid);
    exe_vld = 1; exe_grp = IW'(g); exe_iid = 8'(iid);
    @(negedge clk); clr();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1; @(negedge clk); clr();
    end
  endtask

  task automatic t_reset();
    check("R1", "ready", int'(grp_ready), 16'hFFFE);
    check("R1", "executed", int'(grp_executed), 16'hFFFE);
    check("R1", "waiting|pending|executing", int'(grp_waiting | grp_pending | grp_executing), 0);
    check("R1", "crit cyc", int'(crit_pred_cyc), 0);
    check("R1", "err", int'(err_flag), 0);
  endtask

  task automatic t_order_edge();
    add_inst(1); add_inst(1); add_inst(2);
    add_succ(1, 2, 0);
    check("R3", "g2 waiting", int'(grp_waiting[2]), 1);
    check("R3", "g2 ready", int'(grp_ready[2]), 0);
    issue(1, 10, 5);
    // R2: two members, one issued is not executing
    check("R2", "g1 executing after 1 of 2", int'(grp_executing[1]), 0);
    check("R5", "g2 waiting before release", int'(grp_waiting[2]), 1);
    issue(1, 11, 3);
    check("R4", "g1 executing", int'(grp_executing[1]), 1);
    check("R5", "g2 ready after release", int'(grp_ready[2]), 1);
    execute(1, 10); execute(1, 11);
    check("R4", "g1 executed", int'(grp_executed[1]), 1);
    check("R4", "g1 executing cleared", int'(grp_executing[1]), 0);
  endtask

  task automatic t_data_edge();
    crit_sel = 4;
    add_inst(3); add_inst(4);
    add_succ(3, 4, 1);
    check("R3", "g4 waiting", int'(grp_waiting[4]), 1);
    issue(3, 20, 7);
    check("R6", "g4 pending", int'(grp_pending[4]), 1);
    check("R8", "g4 crit cyc", int'(crit_pred_cyc), 7);
    check("R8", "g4 crit iid", int'(crit_pred_iid), 20);
    ticks(1);
    check("R9", "no countdown when pending", int'(crit_pred_cyc), 7);
    execute(3, 20);
    check("R6", "g4 ready", int'(grp_ready[4]), 1);
    check("R6", "g4 pending cleared", int'(grp_pending[4]), 0);
  endtask

  task automatic t_countdown();
    crit_sel = 7;
    add_inst(5); add_inst(5); add_inst(6);
    add_succ(5, 7, 1); add_succ(6, 7, 1);
    issue(5, 30, 9);
    check("R10", "no pass before full issue", int'(crit_pred_cyc), 0);
    issue(5, 33, 2);
    check("R10", "largest member cyc passed", int'(crit_pred_cyc), 9);
    check("R10", "largest member iid passed", int'(crit_pred_iid), 30);
    check("R3", "g7 waiting 1 of 2", int'(grp_waiting[7]), 1);
    ticks(3);
    check("R9", "countdown 3 ticks", int'(crit_pred_cyc), 6);
    issue(6, 31, 4);
    check("R8", "smaller does not replace cyc", int'(crit_pred_cyc), 6);
    check("R8", "smaller does not replace iid", int'(crit_pred_iid), 30);
    check("R3", "g7 pending", int'(grp_pending[7]), 1);
    ticks(1);
    check("R9", "hold when pending", int'(crit_pred_cyc), 6);
  endtask

  task automatic t_late_edges();
    crit_sel = 9;
    add_inst(8);
    issue(8, 40, 12);
    check("R4", "g8 executing", int'(grp_executing[8]), 1);
    add_succ(8, 9, 1);
    check("R7", "late data edge pending", int'(grp_pending[9]), 1);
    check("R7", "late data edge crit", int'(crit_pred_cyc), 12);
    add_succ(8, 10, 0);
    check("R7", "late order edge dropped", int'(grp_ready[10]), 1);
    add_inst(10);
    check("R7", "no lock from dropped edge", int'(err_flag), 0);
  endtask

  task automatic t_crit_clear();
    crit_sel = 14;
    add_inst(13); add_inst(13);
    issue(13, 60, 5); issue(13, 61, 3);
    execute(13, 60);
    check("R4", "g13 still executing", int'(grp_executing[13]), 1);
    add_succ(13, 14, 1);
    check("R10", "cleared critical not passed", int'(crit_pred_cyc), 0);
    check("R7", "g14 pending", int'(grp_pending[14]), 1);
  endtask

  task automatic t_same_cycle();
    add_inst(11); add_inst(12);
    add_succ(11, 12, 1);
    iss_vld = 1; iss_grp = 4'd11; iss_iid = 8'd50; iss_cyc = 8'd6;
    exe_vld = 1; exe_grp = 4'd11; exe_iid = 8'd50;
    @(negedge clk); clr();
    check("R11", "issue+exec executed", int'(grp_executed[11]), 1);
    check("R11", "successor ready", int'(grp_ready[12]), 1);
    check("R11", "no error", int'(err_flag), 0);
  endtask

  task automatic t_illegal();
    add_inst(8);
    check("R12", "err set", int'(err_flag), 1);
    check("R2", "g8 unchanged executing", int'(grp_executing[8]), 1);
    @(negedge clk);
    check("R12", "err sticky", int'(err_flag), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_order_edge();
    t_data_edge();
    t_countdown();
    t_late_edges();
    t_crit_clear();
    t_same_cycle();
    t_illegal();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule